// File: doc/BRIEF.md
# Flash Self-Programming Sequencer

This block lets a small processor rewrite its own program flash. The processor writes an 8-bit control register on its I/O bus. Setting the enable bit, together with at most one command, arms a short window. Inside that window a store-program or load-program instruction strobe from the processor turns the armed command into a single-cycle request to the flash macro. The possible requests are page erase, page write, temporary-buffer word fill, temporary-buffer clear, and fuse/lock readback.

During a page erase or page write the block raises a stall toward the processor for a fixed number of cycles. The fixed count stands in for the oscillator-timed programming delay of 3.7 to 4.5 ms. When the count runs out, the block pulses a done output and clears the register by itself.

If the armed window passes without a matching instruction, the command lapses. Writes that arrive while a command is armed or running are dropped. The page number is taken from the upper bits of the 16-bit Z pointer. The processor's data registers are not used for erase or write.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and busy, stall and all flash request outputs are low. Register bits 7..5 always read 0.
- R2: Register layout: bit0 enable, bit1 erase, bit2 write, bit3 fuse read, bit4 buffer clear. A write is stored only when bit0 is 1 and the register's enable bit is currently 0. Any other write leaves the register unchanged.
- R3: When one write sets several command bits, only the one with the highest priority is kept. The order is erase, then write, then fuse read, then buffer clear. For example, writing 0xFF reads back 0x03 and writing 0x0D reads back 0x05.
- R4: Erase (0x03) or write (0x05) is armed. If a store strobe is sampled on one of the 1st to 4th rising edges after the register write, the block drives a one-cycle pulse on fl_erase_o or fl_write_o in the following cycle. In that cycle fl_page_o holds Z[15:5].
- R5: If no store strobe arrives within those 4 edges, the register returns to 0x00 on the 4th edge. A store strobe after that point has no effect.
- R6: busy_o and stall_o stay high for exactly PROG_CYCLES cycles, starting in the cycle of the erase or write request pulse. done_o is high only in the last of those cycles, and the register reads 0x00 in the cycle after it.
- R7: Fuse read (0x09) is armed. A load strobe on one of the 1st to 3rd edges after the write pulses fl_fuse_rd_o in the next cycle, with fl_fuse_sel_o equal to Z[0], and the register clears. A load strobe after the 3rd edge, or a store strobe at any time, is ignored.
- R8: Writing 0x11 drives fl_buf_clr_o high for the single cycle after the write, and the register then clears. Writing 0x10, with enable clear, does nothing.
- R9: With enable alone (0x01) armed, a store strobe within 4 edges pulses fl_fill_o in the next cycle with {fl_page_o, fl_word_o} equal to Z[15:1], and the register clears. A load strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| spm_i | input | 1 | Store-program instruction strobe |
| lpm_i | input | 1 | Load-program instruction strobe |
| z_i | input | 16 | Z pointer |
| stall_o | output | 1 | Processor stall |
| busy_o | output | 1 | Erase/write in progress |
| done_o | output | 1 | Last busy cycle |
| fl_erase_o | output | 1 | Page erase request pulse |
| fl_write_o | output | 1 | Page write request pulse |
| fl_fill_o | output | 1 | Buffer word fill pulse |
| fl_buf_clr_o | output | 1 | Temporary buffer clear pulse |
| fl_fuse_rd_o | output | 1 | Fuse/lock read pulse |
| fl_fuse_sel_o | output | 1 | 1 = fuse bits, 0 = lock bits (Z[0]) |
| fl_page_o | output | 16-PAGE_LSB | Page number from Z |
| fl_word_o | output | PAGE_LSB-1 | Word index within the page, for fill |

## Verification
Store strobes are sent 1, 2 and 4 edges after arming, and also at 5 edges. This separates a window that is the correct length from one that is a cycle short or a cycle long. Load strobes are sent at the 1st and 3rd edge and then at the 4th, which probes the shorter fuse window the same way. Writes that set several command bits, writes without enable, writes while armed and writes while busy show whether the priority order holds and whether the register is locked at the right times. Strobes of the wrong kind in each armed mode show that a command responds only to its own instruction. The bench measures each erase and write from stall rise to fall, checks where done lands, and confirms the page reported against the Z value that was driven.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int BIT_EN  = 0;
  localparam int BIT_ERS = 1;
  localparam int BIT_WRT = 2;
  localparam int BIT_FUS = 3;
  localparam int BIT_CLR = 4;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_ERASE, CMD_WRITE, CMD_FUSE, CMD_CLR
  } cmd_e;

  // priority: erase > write > fuse > clear
  function automatic cmd_e pick_cmd(input logic [4:0] d);
    if (d[BIT_ERS])      return CMD_ERASE;
    else if (d[BIT_WRT]) return CMD_WRITE;
    else if (d[BIT_FUS]) return CMD_FUSE;
    else if (d[BIT_CLR]) return CMD_CLR;
    else                 return CMD_NONE;
  endfunction

  function automatic logic [4:0] cmd_bits(input cmd_e c);
    logic [4:0] b;
    b = 5'b00001;
    case (c)
      CMD_ERASE: b[BIT_ERS] = 1'b1;
      CMD_WRITE: b[BIT_WRT] = 1'b1;
      CMD_FUSE:  b[BIT_FUS] = 1'b1;
      CMD_CLR:   b[BIT_CLR] = 1'b1;
      default:   ;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/fsp_arm_window.sv
module fsp_arm_window #(
  parameter int SPM_WIN = 4,
  parameter int LPM_WIN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic short_i,
  input  logic hit_i,
  output logic expire_o
);
  localparam int WMAX = (SPM_WIN > LPM_WIN) ? SPM_WIN : LPM_WIN;
  localparam int CW   = $clog2(WMAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= short_i ? CW'(LPM_WIN) : CW'(SPM_WIN);
    else if (hit_i)           cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == CW'(1)) && !hit_i;
endmodule

// File: rtl/fsp_prog_timer.sv
module fsp_prog_timer #(
  parameter int PROG_CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [TW-1:0] tmr_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tmr_q  <= TW'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (tmr_q == '0) busy_q <= 1'b0;
      else             tmr_q  <= tmr_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (tmr_q == '0);
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import fsp_pkg::*;
#(
  parameter int PROG_CYCLES = 40,
  parameter int SPM_WIN     = 4,
  parameter int LPM_WIN     = 3,
  parameter int PAGE_LSB    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  input  logic                 spm_i,
  input  logic                 lpm_i,
  input  logic [15:0]          z_i,
  output logic                 stall_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 fl_erase_o,
  output logic                 fl_write_o,
  output logic                 fl_fill_o,
  output logic                 fl_buf_clr_o,
  output logic                 fl_fuse_rd_o,
  output logic                 fl_fuse_sel_o,
  output logic [15-PAGE_LSB:0] fl_page_o,
  output logic [PAGE_LSB-2:0]  fl_word_o
);
  localparam int PAGE_W = 16 - PAGE_LSB;

  logic [4:0]        ctl_q;
  cmd_e              cur_cmd, new_cmd;
  logic              wr_ok, spm_hit, lpm_hit, start, expire, busy, done, clr_now;
  logic              ers_q, wrt_q, fill_q, fuse_q, sel_q;
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_LSB-2:0] word_q;
  logic              unused_rsvd;

  assign unused_rsvd = ^reg_wdata_i[7:5];
  assign cur_cmd = pick_cmd(ctl_q);
  assign new_cmd = pick_cmd(reg_wdata_i[4:0]);

  assign wr_ok   = reg_we_i && reg_wdata_i[BIT_EN] && !ctl_q[BIT_EN];
  assign spm_hit = spm_i && ctl_q[BIT_EN] && !busy &&
                   (cur_cmd == CMD_ERASE || cur_cmd == CMD_WRITE || cur_cmd == CMD_NONE);
  assign lpm_hit = lpm_i && ctl_q[BIT_EN] && (cur_cmd == CMD_FUSE);
  assign start   = spm_hit && (cur_cmd != CMD_NONE);
  assign clr_now = ctl_q[BIT_CLR];

  fsp_arm_window #(.SPM_WIN(SPM_WIN), .LPM_WIN(LPM_WIN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wr_ok),
    .short_i  (new_cmd == CMD_FUSE),
    .hit_i    (spm_hit || lpm_hit || clr_now),
    .expire_o (expire)
  );

  fsp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ctl_q <= '0;
    else if (wr_ok)
      ctl_q <= cmd_bits(new_cmd);
    else if (done || (expire && !busy) || lpm_hit || (spm_hit && !start) || clr_now)
      ctl_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ers_q  <= 1'b0;
      wrt_q  <= 1'b0;
      fill_q <= 1'b0;
      fuse_q <= 1'b0;
      sel_q  <= 1'b0;
      page_q <= '0;
      word_q <= '0;
    end else begin
      ers_q  <= start && (cur_cmd == CMD_ERASE);
      wrt_q  <= start && (cur_cmd == CMD_WRITE);
      fill_q <= spm_hit && !start;
      fuse_q <= lpm_hit;
      if (lpm_hit) sel_q <= z_i[0];
      if (spm_hit) begin
        page_q <= z_i[15:PAGE_LSB];
        word_q <= z_i[PAGE_LSB-1:1];
      end
    end
  end

  assign reg_rdata_o   = {3'b000, ctl_q};
  assign busy_o        = busy;
  assign stall_o       = busy;
  assign done_o        = done;
  assign fl_erase_o    = ers_q;
  assign fl_write_o    = wrt_q;
  assign fl_fill_o     = fill_q;
  assign fl_buf_clr_o  = clr_now;
  assign fl_fuse_rd_o  = fuse_q;
  assign fl_fuse_sel_o = sel_q;
  assign fl_page_o     = page_q;
  assign fl_word_o     = word_q;
endmodule

// File: rtl/fsp_checks.sv
module fsp_checks #(
  parameter int SPM_WIN = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       spm_i,
  input logic       lpm_i,
  input logic [7:0] reg_rdata_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       fl_erase_o,
  input logic       fl_write_o,
  input logic       fl_fill_o,
  input logic       fl_buf_clr_o,
  input logic       fl_fuse_rd_o
);
  int arm_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           arm_cnt <= 0;
    else if (reg_rdata_o[0] && !busy_o)    arm_cnt <= arm_cnt + 1;
    else                                   arm_cnt <= 0;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:5] == 3'b000); // R1
  AST_CMD_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|reg_rdata_o[4:1]) |-> reg_rdata_o[0]); // R2
  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_rdata_o[4:1])); // R3
  AST_START_FROM_SPM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_erase_o || fl_write_o) |-> ($past(spm_i) && busy_o)); // R4
  AST_WINDOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_cnt <= SPM_WIN); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && reg_rdata_o == 8'h00)); // R6
  AST_BUSY_KEEPS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (reg_rdata_o[0] && (reg_rdata_o[1] || reg_rdata_o[2]))); // R6
  AST_FUSE_FROM_LPM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_fuse_rd_o |-> $past(lpm_i)); // R7
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_buf_clr_o |=> !fl_buf_clr_o); // R8
  AST_FILL_FROM_SPM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_fill_o |-> ($past(spm_i) && !busy_o)); // R9
endmodule

bind flash_selfprog_ctrl fsp_checks #(.SPM_WIN(SPM_WIN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .spm_i        (spm_i),
  .lpm_i        (lpm_i),
  .reg_rdata_o  (reg_rdata_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fl_erase_o   (fl_erase_o),
  .fl_write_o   (fl_write_o),
  .fl_fill_o    (fl_fill_o),
  .fl_buf_clr_o (fl_buf_clr_o),
  .fl_fuse_rd_o (fl_fuse_rd_o)
);

// File: tb/sim_flash_selfprog_ctrl.sv
`timescale 1ns/100ps
module sim_flash_selfprog_ctrl;
  localparam int PROG     = 24;
  localparam int PAGE_LSB = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we = 1'b0, spm = 1'b0, lpm = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [15:0] z = '0;
  logic stall, busy, done, ers, wrt, fill, bclr, fuse, fsel;
  logic [15-PAGE_LSB:0] page;
  logic [PAGE_LSB-2:0] word;

  always #2.5 clk = ~clk;

  flash_selfprog_ctrl #(.PROG_CYCLES(PROG), .PAGE_LSB(PAGE_LSB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .spm_i(spm), .lpm_i(lpm), .z_i(z), .stall_o(stall),
    .busy_o(busy), .done_o(done), .fl_erase_o(ers), .fl_write_o(wrt),
    .fl_fill_o(fill), .fl_buf_clr_o(bclr), .fl_fuse_rd_o(fuse),
    .fl_fuse_sel_o(fsel), .fl_page_o(page), .fl_word_o(word));

  // kinds: 1 erase, 2 write, 3 fill, 4 fuse read, 5 buffer clear
  typedef struct { int kind; int arg; string req; } ev_t;
  ev_t exp_q[$];
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input int kind, input int arg, input string req);
    ev_t e;
    e.kind = kind; e.arg = arg; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops expected flash requests as they appear
  always @(negedge clk) begin
    if (rst_ni) begin
      int kind, arg;
      kind = 0; arg = 0;
      if (ers)       begin kind = 1; arg = int'(page); end
      else if (wrt)  begin kind = 2; arg = int'(page); end
      else if (fill) begin kind = 3; arg = int'({page, word}); end
      else if (fuse) begin kind = 4; arg = int'(fsel); end
      else if (bclr) begin kind = 5; arg = 0; end
      if (kind != 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected flash request", kind, 0);
        else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(e.kind == kind && e.arg == arg, e.req, kind * 65536 + arg, e.kind * 65536 + e.arg);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic strobe(input bit is_spm, input int dly, input logic [15:0] zv);
    repeat (dly - 1) @(negedge clk);
    z = zv;
    if (is_spm) spm = 1'b1; else lpm = 1'b1;
    @(negedge clk);
    spm = 1'b0; lpm = 1'b0;
  endtask

  task automatic wait_busy(input int exp_n);
    int n = 0, dn = 0;
    bit last_done = 1'b0, bad_stall = 1'b0;
    while (busy) begin
      if (!stall) bad_stall = 1'b1;
      if (done) dn++;
      last_done = done;
      n++;
      @(negedge clk);
    end
    chk(n == exp_n, "R6 busy length", n, exp_n);
    chk(last_done && dn == 1, "R6 done only in last busy cycle", dn, 1);
    chk(!bad_stall, "R6 stall follows busy", bad_stall, 0);
    chk(rdata == 8'h00, "R6 register auto-clears", rdata, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata == 8'h00 && !busy && !stall && !ers && !wrt && !fill && !bclr && !fuse,
        "R1 reset state", rdata, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 priority and R1 reserved bits; erase at edge 2
    wr(8'hFF);
    chk(rdata == 8'h03, "R3 0xFF keeps erase only", rdata, 8'h03);
    push(1, 16'hABCD >> 5, "R4 erase page");
    strobe(1'b1, 2, 16'hABCD);
    wait_busy(PROG);

    // R4 write at edge 4
    wr(8'h05);
    push(2, 16'h1234 >> 5, "R4 write page at edge 4");
    strobe(1'b1, 4, 16'h1234);
    wait_busy(PROG);

    // R5 expiry
    wr(8'h03);
    repeat (3) @(negedge clk);
    chk(rdata == 8'h03, "R5 still armed after 3 edges", rdata, 8'h03);
    @(negedge clk);
    chk(rdata == 8'h00, "R5 cleared after 4 edges", rdata, 0);
    strobe(1'b1, 1, 16'hFFFF);
    repeat (3) @(negedge clk);
    chk(!busy, "R5 late store strobe ignored", busy, 0);

    // R2 write without enable
    wr(8'h04);
    chk(rdata == 8'h00, "R2 no enable not stored", rdata, 0);
    strobe(1'b1, 1, 16'h0000);
    @(negedge clk);
    chk(!busy, "R2 no start without enable", busy, 0);

    // R2 write while armed ignored, then erase at edge 1 of remaining
    wr(8'h03);
    wr(8'h05);
    chk(rdata == 8'h03, "R2 write while armed ignored", rdata, 8'h03);
    push(1, 16'hF800 >> 5, "R4 erase after ignored write");
    strobe(1'b1, 1, 16'hF800);
    wait_busy(PROG);

    // R2 write while busy ignored
    wr(8'h05);
    push(2, 16'h0420 >> 5, "R4 write page at edge 1");
    strobe(1'b1, 1, 16'h0420);
    wr(8'h03);
    chk(rdata == 8'h05, "R2 write while busy ignored", rdata, 8'h05);
    wait_busy(PROG - 2);

    // R7 fuse read, select 1 at edge 3
    wr(8'h09);
    push(4, 1, "R7 fuse select 1");
    strobe(1'b0, 3, 16'h0001);
    chk(rdata == 8'h00, "R7 clears after load", rdata, 0);

    // R7 select 0 at edge 1
    wr(8'h09);
    push(4, 0, "R7 lock select 0");
    strobe(1'b0, 1, 16'hFFFE);

    // R7 store ignored, load at edge 4 too late
    wr(8'h09);
    strobe(1'b1, 1, 16'h2000);
    chk(rdata == 8'h09 && !busy, "R7 store strobe ignored in fuse mode", rdata, 8'h09);
    strobe(1'b0, 3, 16'h0001);
    chk(rdata == 8'h00, "R7 window is 3 edges", rdata, 0);
    @(negedge clk);

    // R3 write beats fuse; load ignored
    wr(8'h0D);
    chk(rdata == 8'h05, "R3 write over fuse", rdata, 8'h05);
    strobe(1'b0, 1, 16'h0001);
    chk(rdata == 8'h05, "R3 load ignored for write", rdata, 8'h05);
    repeat (4) @(negedge clk);
    chk(rdata == 8'h00 && !busy, "R5 write command lapses", rdata, 0);

    // R8 buffer clear
    push(5, 0, "R8 buffer clear");
    wr(8'h11);
    chk(rdata == 8'h11, "R8 clear visible one cycle", rdata, 8'h11);
    @(negedge clk);
    chk(rdata == 8'h00 && !bclr, "R8 clear drops", rdata, 0);
    wr(8'h10);
    @(negedge clk);
    chk(rdata == 8'h00, "R8 clear without enable ignored", rdata, 0);

    // R9 fill
    wr(8'h01);
    strobe(1'b0, 1, 16'h0001);
    chk(rdata == 8'h01, "R9 load ignored in fill mode", rdata, 8'h01);
    push(3, 16'h0046 >> 1, "R9 fill address");
    strobe(1'b1, 1, 16'h0046);
    chk(rdata == 8'h00 && !busy, "R9 fill clears without stall", rdata, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected requests seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule